// File: doc/BRIEF.md
# Segmented Address Translation Checker

This block turns one memory access into a linear address, or a fault. Each access supplies the attributes of the segment as cached from its descriptor: base, limit, granularity, code/data type, writability, presence, a null-selector marker and the 16/32-bit size. It also supplies an offset, the access kind (instruction fetch, read or write) and the access width. In protected mode the offset is checked against the scaled limit and the segment type, then added to the 32-bit base. In real mode the 16-bit segment value is shifted left by four and added to the 16-bit offset, giving a 20-bit address.

All checking and address forming is combinational. One output register stage presents the result one clock after the request. A fault reports a code that names the cause, and a faulting access never raises the address-valid strobe. Paging, fault delivery and privilege levels lie outside the block.

Top module: `seg_xlate`

## Requirements
- R1: In real mode (`prot_mode`=0) the address is `(seg_sel*16 + offset[15:0])` truncated to 20 bits, so a carry into bit 20 is lost. Upper bits are zero, `offset[31:16]` and every descriptor input are ignored, and the access never faults.
- R2: In protected mode an access that passes every check yields `desc_base + offset_eff` modulo 2^32.
- R3: With `desc_big`=0 (16-bit segment) `offset_eff` is `offset[15:0]` zero-extended, and `offset[31:16]` has no effect. With `desc_big`=1 it is the full 32-bit offset.
- R4: With `desc_gran`=0 the limit counts bytes: the access faults with code 4 (limit) when `offset_eff + size_m1 > desc_limit`.
- R5: With `desc_gran`=1 the effective limit is `{desc_limit, 12'hFFF}`, so a limit of FFFFFh accepts every single-byte offset up to FFFFFFFFh.
- R6: `size_m1` (0..3) is the access width in bytes minus one. A multi-byte access whose last byte passes the effective limit faults with code 4, even when its first byte lies inside the limit.
- R7: `kind` encodes 0 fetch, 1 read, 2 write, 3 read. Three accesses fault with code 3 (type): a write to a code segment (`desc_code`=1), a fetch from a data segment, and a write to a data segment with `desc_writable`=0. Reads and fetches of code segments are allowed.
- R8: In protected mode an access with `desc_null`=1 faults with code 1, whatever the other inputs are.
- R9: In protected mode an access with `desc_present`=0 and `desc_null`=0 faults with code 2.
- R10: When several violations coincide, the reported code follows the priority null (1) > not present (2) > type (3) > limit (4). Code 0 means no fault.
- R11: The results of a request appear on the outputs exactly one clock after it. On a fault `out_valid`=0 and `out_addr`=0. In a cycle after no request, `out_valid`, `out_fault`, `out_code` and `out_addr` are all zero.
- R12: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| prot_mode | input | 1 | 1 protected mode, 0 real mode |
| kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 read |
| size_m1 | input | 2 | Access width in bytes minus one |
| seg_sel | input | 16 | Segment register value used in real mode |
| desc_base | input | 32 | Cached segment base |
| desc_limit | input | 20 | Cached segment limit |
| desc_gran | input | 1 | Limit unit: 0 byte, 1 4K page |
| desc_code | input | 1 | Segment is executable |
| desc_writable | input | 1 | Data segment accepts writes |
| desc_present | input | 1 | Segment is present |
| desc_null | input | 1 | Register holds the null selector |
| desc_big | input | 1 | 32-bit segment (else 16-bit offset) |
| offset | input | 32 | Access offset |
| out_valid | output | 1 | Translated address is valid |
| out_fault | output | 1 | Access faulted |
| out_code | output | 3 | Fault cause: 0 none, 1 null, 2 absent, 3 type, 4 limit |
| out_addr | output | 32 | Linear address |

## Verification
All four results of a request (strobe, fault flag, cause code and address) are due at the first rising edge after the request is applied, and never later. The bench drives each request on a falling edge. It computes the expected result from the requirements at that moment and compares it at the next falling edge, half a period after the capturing edge. Idle cycles are compared the same way against all-zero outputs. Back-to-back requests with no idle cycle between them show that each result belongs to its own request and no later one.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_READX = 2'd3
   } acc_kind_t;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_NULL   = 3'd1,
      FLT_ABSENT = 3'd2,
      FLT_TYPE   = 3'd3,
      FLT_LIMIT  = 3'd4
   } flt_code_t;

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int ADDR_W      = 32,
   parameter int SEG_W       = 16,
   parameter int SHORT_OFF_W = 16,
   parameter int REAL_SHIFT  = 4,
   parameter int REAL_W      = 20
) (
   input  logic              prot_mode,
   input  logic              big,
   input  logic [SEG_W-1:0]  seg,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   output logic [ADDR_W-1:0] off_eff,
   output logic [ADDR_W-1:0] lin_addr
);
   localparam int SH_W = SEG_W + REAL_SHIFT;

   logic [SH_W-1:0]        seg_sh;
   logic [SH_W-1:0]        real_sum;
   logic [SHORT_OFF_W-1:0] off_short;
   logic [ADDR_W-1:0]      prot_sum;

   if (SH_W != REAL_W) begin : g_bad_real
      $error("seg_addr_gen: SEG_W + REAL_SHIFT must equal REAL_W");
   end
   if (SHORT_OFF_W > SH_W || REAL_W > ADDR_W) begin : g_bad_short
      $error("seg_addr_gen: width ordering violated");
   end

   assign off_short = offset[SHORT_OFF_W-1:0];
   assign seg_sh    = {seg, {REAL_SHIFT{1'b0}}};

   always_comb begin
      real_sum = seg_sh + {{(SH_W-SHORT_OFF_W){1'b0}}, off_short};
      off_eff  = big ? offset : {{(ADDR_W-SHORT_OFF_W){1'b0}}, off_short};
      prot_sum = base + off_eff;
      lin_addr = prot_mode ? prot_sum : {{(ADDR_W-REAL_W){1'b0}}, real_sum};
   end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
   parameter int ADDR_W = 32,
   parameter int LIM_W  = 20,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] off_eff,
   input  logic [SIZE_W-1:0] size_m1,
   input  logic [LIM_W-1:0]  limit,
   input  logic              gran,
   output logic              over
);
   localparam int GRAN_SHIFT = ADDR_W - LIM_W;

   logic [ADDR_W-1:0] eff_lim;
   logic [ADDR_W:0]   last_byte;

   if (GRAN_SHIFT <= 0 || SIZE_W >= ADDR_W) begin : g_bad_lim
      $error("seg_limit_chk: limit must be narrower than the address");
   end

   always_comb begin
      eff_lim   = gran ? {limit, {GRAN_SHIFT{1'b1}}}
                       : {{GRAN_SHIFT{1'b0}}, limit};
      last_byte = {1'b0, off_eff} + {{(ADDR_W+1-SIZE_W){1'b0}}, size_m1};
      over      = last_byte > {1'b0, eff_lim};
   end
endmodule

// File: rtl/seg_type_chk.sv
module seg_type_chk
   import seg_xlate_pkg::*;
#(
   parameter bit STRICT_RO = 1'b1
) (
   input  logic [1:0] kind,
   input  logic       is_code,
   input  logic       writable,
   output logic       viol
);
   acc_kind_t acc;
   logic      base_viol;

   assign acc = acc_kind_t'(kind);

   always_comb begin
      base_viol = 1'b0;
      unique case (acc)
         ACC_FETCH: base_viol = !is_code;
         ACC_WRITE: base_viol = is_code;
         default:   base_viol = 1'b0;
      endcase
   end

   if (STRICT_RO) begin : g_ro_check
      assign viol = base_viol || (acc == ACC_WRITE && !is_code && !writable);
   end else begin : g_no_ro
      logic unused_wr;
      assign unused_wr = writable;
      assign viol      = base_viol;
   end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LIM_W       = 20,
   parameter int SEG_W       = 16,
   parameter int SHORT_OFF_W = 16,
   parameter int REAL_SHIFT  = 4,
   parameter int SIZE_W      = 2,
   parameter bit STRICT_RO   = 1'b1,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              prot_mode,
   input  logic [1:0]        kind,
   input  logic [SIZE_W-1:0] size_m1,
   input  logic [SEG_W-1:0]  seg_sel,
   input  logic [ADDR_W-1:0] desc_base,
   input  logic [LIM_W-1:0]  desc_limit,
   input  logic              desc_gran,
   input  logic              desc_code,
   input  logic              desc_writable,
   input  logic              desc_present,
   input  logic              desc_null,
   input  logic              desc_big,
   input  logic [ADDR_W-1:0] offset,
   output logic              out_valid,
   output logic              out_fault,
   output logic [2:0]        out_code,
   output logic [ADDR_W-1:0] out_addr
);
   localparam int REAL_W = SEG_W + REAL_SHIFT;

   if (LIM_W >= ADDR_W) begin : g_bad_lim
      $error("seg_xlate: LIM_W must be below ADDR_W");
   end
   if (REAL_W > ADDR_W || SHORT_OFF_W > ADDR_W) begin : g_bad_real
      $error("seg_xlate: real-mode widths exceed ADDR_W");
   end

   logic [ADDR_W-1:0] off_eff;
   logic [ADDR_W-1:0] lin_addr;
   logic              lim_over;
   logic              type_bad;
   flt_code_t         code_n;
   logic              nx_valid;
   logic              nx_fault;
   logic [2:0]        nx_code;
   logic [ADDR_W-1:0] nx_addr;

   seg_addr_gen #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W), .SHORT_OFF_W(SHORT_OFF_W),
      .REAL_SHIFT(REAL_SHIFT), .REAL_W(REAL_W)
   ) u_addr (
      .prot_mode(prot_mode), .big(desc_big), .seg(seg_sel),
      .base(desc_base), .offset(offset),
      .off_eff(off_eff), .lin_addr(lin_addr)
   );

   seg_limit_chk #(
      .ADDR_W(ADDR_W), .LIM_W(LIM_W), .SIZE_W(SIZE_W)
   ) u_lim (
      .off_eff(off_eff), .size_m1(size_m1), .limit(desc_limit),
      .gran(desc_gran), .over(lim_over)
   );

   seg_type_chk #(
      .STRICT_RO(STRICT_RO)
   ) u_type (
      .kind(kind), .is_code(desc_code), .writable(desc_writable),
      .viol(type_bad)
   );

   // fault priority: null, absent, type, limit
   always_comb begin
      code_n = FLT_NONE;
      if (prot_mode) begin
         if (desc_null)          code_n = FLT_NULL;
         else if (!desc_present) code_n = FLT_ABSENT;
         else if (type_bad)      code_n = FLT_TYPE;
         else if (lim_over)      code_n = FLT_LIMIT;
      end
   end

   always_comb begin
      nx_valid = req_valid && (code_n == FLT_NONE);
      nx_fault = req_valid && (code_n != FLT_NONE);
      nx_code  = req_valid ? code_n : FLT_NONE;
      nx_addr  = nx_valid ? lin_addr : '0;
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_code  <= 3'd0;
            out_addr  <= '0;
         end else begin
            out_valid <= nx_valid;
            out_fault <= nx_fault;
            out_code  <= nx_code;
            out_addr  <= nx_addr;
         end
      end
   end else begin : g_comb_out
      logic unused_clk;
      assign unused_clk = clk;
      assign out_valid  = rst_n && nx_valid;
      assign out_fault  = rst_n && nx_fault;
      assign out_code   = rst_n ? nx_code : 3'd0;
      assign out_addr   = rst_n ? nx_addr : '0;
   end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int ADDR_W = 32,
   parameter int REAL_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              prot_mode,
   input logic [1:0]        kind,
   input logic              desc_code,
   input logic              desc_present,
   input logic              desc_null,
   input logic              out_valid,
   input logic              out_fault,
   input logic [2:0]        out_code,
   input logic [ADDR_W-1:0] out_addr
);
   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_fault);

   p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_code != 3'd0 && out_code <= 3'd4));

   p_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_fault |-> (out_code == 3'd0 && (out_valid || out_addr == '0)));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && !out_fault));

   p_real_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_mode) |=> (out_valid && out_addr[ADDR_W-1:REAL_W] == '0));

   p_null_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_mode && desc_null) |=> (out_fault && out_code == 3'd1));

   p_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_mode && !desc_null && !desc_present) |=> (out_code == 3'd2));

   p_wr_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_mode && !desc_null && desc_present && kind == 2'd2 && desc_code)
      |=> (out_fault && out_code == 3'd3));
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, prot_mode;
   logic [1:0]  kind, size_m1;
   logic [15:0] seg_sel;
   logic [31:0] desc_base, offset;
   logic [19:0] desc_limit;
   logic        desc_gran, desc_code, desc_writable, desc_present, desc_null, desc_big;
   logic        out_valid, out_fault;
   logic [2:0]  out_code;
   logic [31:0] out_addr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   seg_xlate u_dut (.*);

   // expected result of the request currently on the inputs
   logic        e_valid, e_fault;
   logic [2:0]  e_code;
   logic [31:0] e_addr;

   task automatic model();
      longint o, lim, a;
      int c;
      c = 0;
      if (!prot_mode) begin
         a = ((longint'(seg_sel) * 16) + longint'(offset & 32'hFFFF)) % (64'd1 << 20);
      end else begin
         o   = desc_big ? longint'(offset) : longint'(offset & 32'hFFFF);
         lim = desc_gran ? (longint'(desc_limit) * 4096 + 4095) : longint'(desc_limit);
         a   = (longint'(desc_base) + o) % (64'd1 << 32);
         if (desc_null) c = 1;
         else if (!desc_present) c = 2;
         else if ((kind == 2 && desc_code) || (kind == 0 && !desc_code) ||
                  (kind == 2 && !desc_code && !desc_writable)) c = 3;
         else if (o + longint'(size_m1) > lim) c = 4;
      end
      if (!req_valid) begin
         e_valid = 0; e_fault = 0; e_code = 0; e_addr = 0;
      end else begin
         e_fault = (c != 0);
         e_valid = (c == 0);
         e_code  = 3'(c);
         e_addr  = (c == 0) ? 32'(a) : 32'd0;
      end
   endtask

   task automatic compare(string tag);
      total++;
      if (out_valid !== e_valid || out_fault !== e_fault ||
          out_code !== e_code || out_addr !== e_addr) begin
         bad++;
         $display("FAIL %s: got valid=%0b fault=%0b code=%0d addr=%h exp valid=%0b fault=%0b code=%0d addr=%h",
                  tag, out_valid, out_fault, out_code, out_addr,
                  e_valid, e_fault, e_code, e_addr);
      end
   endtask

   // called at a falling edge: drive, then check one clock later
   task automatic step(string tag);
      model();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(string tag);
      req_valid = 0;
      step(tag);
   endtask

   task automatic prot(string tag, logic [1:0] k, logic [1:0] sz, logic [31:0] b,
                       logic [19:0] l, logic g, logic cd, logic wr, logic pr,
                       logic nl, logic bg, logic [31:0] off);
      req_valid = 1; prot_mode = 1; kind = k; size_m1 = sz; desc_base = b;
      desc_limit = l; desc_gran = g; desc_code = cd; desc_writable = wr;
      desc_present = pr; desc_null = nl; desc_big = bg; offset = off;
      seg_sel = 16'h5A5A;
      step(tag);
   endtask

   task automatic realm(string tag, logic [15:0] s, logic [31:0] off);
      req_valid = 1; prot_mode = 0; seg_sel = s; offset = off;
      kind = 2; size_m1 = 3; desc_null = 1; desc_present = 0; desc_code = 1;
      desc_limit = 0; desc_gran = 0; desc_writable = 0; desc_big = 1;
      desc_base = 32'hDEAD0000;
      step(tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got no finish, exp finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; req_valid = 1; prot_mode = 0; kind = 0; size_m1 = 0;
      seg_sel = 16'h1234; desc_base = 0; desc_limit = 0; desc_gran = 0;
      desc_code = 0; desc_writable = 0; desc_present = 1; desc_null = 0;
      desc_big = 1; offset = 32'h22;
      repeat (3) @(negedge clk);
      // R12 reset state
      e_valid = 0; e_fault = 0; e_code = 0; e_addr = 0;
      compare("R12 reset");
      rst_n = 1;
      req_valid = 0;
      idle("R11 idle after reset");

      // R1 real mode
      realm("R1 real basic", 16'h1234, 32'h0000_0022);
      if (out_addr !== 32'h0001_2362) begin
         bad++; $display("FAIL R1 addr: got %h exp %h", out_addr, 32'h12362);
      end
      total++;
      realm("R1 carry dropped", 16'hFFFF, 32'h0000_0010);
      realm("R1 high offset ignored", 16'hFFFF, 32'hABCD_0010);
      idle("R11 idle");

      // R2 protected sum and wrap
      prot("R2 base plus offset", 1, 0, 32'h0010_0000, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'h1234);
      prot("R2 wrap modulo 2^32", 1, 0, 32'hF000_0000, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'h2000_0000);

      // R3 16-bit segment
      prot("R3 short offset", 1, 0, 32'h1000, 20'h00100, 0, 0, 1, 1, 0, 0, 32'h0005_0010);
      prot("R3 big offset limit", 1, 0, 32'h1000, 20'h00100, 0, 0, 1, 1, 0, 1, 32'h0005_0010);

      // R4 byte granularity
      prot("R4 at limit", 1, 0, 32'h0, 20'h000FF, 0, 0, 1, 1, 0, 1, 32'hFF);
      prot("R4 past limit", 1, 0, 32'h0, 20'h000FF, 0, 0, 1, 1, 0, 1, 32'h100);

      // R5 4K granularity
      prot("R5 page limit edge", 1, 0, 32'h0, 20'h00001, 1, 0, 1, 1, 0, 1, 32'h1FFF);
      prot("R5 page limit past", 1, 0, 32'h0, 20'h00001, 1, 0, 1, 1, 0, 1, 32'h2000);
      prot("R5 full 4GB top byte", 1, 0, 32'h0, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'hFFFF_FFFF);

      // R6 multi-byte crossing
      prot("R6 dword inside", 1, 3, 32'h0, 20'h000FF, 0, 0, 1, 1, 0, 1, 32'hFC);
      prot("R6 dword crossing", 1, 3, 32'h0, 20'h000FF, 0, 0, 1, 1, 0, 1, 32'hFD);
      prot("R6 word at top ok", 1, 1, 32'h0, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'hFFFF_FFFE);
      prot("R6 dword past top", 1, 3, 32'h0, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'hFFFF_FFFE);

      // R7 type rules
      prot("R7 write code", 2, 0, 32'h0, 20'hFFFFF, 1, 1, 1, 1, 0, 1, 32'h10);
      prot("R7 fetch data", 0, 0, 32'h0, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'h10);
      prot("R7 write rw data", 2, 0, 32'h0, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'h10);
      prot("R7 write ro data", 2, 0, 32'h0, 20'hFFFFF, 1, 0, 0, 1, 0, 1, 32'h10);
      prot("R7 read code", 1, 0, 32'h0, 20'hFFFFF, 1, 1, 0, 1, 0, 1, 32'h10);
      prot("R7 fetch code", 0, 0, 32'h0, 20'hFFFFF, 1, 1, 0, 1, 0, 1, 32'h10);
      prot("R7 kind3 ro data", 3, 0, 32'h0, 20'hFFFFF, 1, 0, 0, 1, 0, 1, 32'h10);

      // R8 / R9 / R10 priority
      prot("R8 null", 1, 0, 32'h0, 20'hFFFFF, 1, 0, 1, 1, 1, 1, 32'h10);
      prot("R8 null beats all", 2, 3, 32'h0, 20'h0, 0, 1, 0, 0, 1, 1, 32'h100);
      prot("R9 absent", 1, 0, 32'h0, 20'hFFFFF, 1, 0, 1, 0, 0, 1, 32'h10);
      prot("R9 absent beats type", 2, 3, 32'h0, 20'h0, 0, 1, 0, 0, 0, 1, 32'h100);
      prot("R10 type beats limit", 2, 3, 32'h0, 20'h0, 0, 1, 0, 1, 0, 1, 32'h100);
      idle("R11 idle after fault");

      // random traffic compared every clock
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 4) == 0) begin
            idle("R11 random idle");
         end else begin
            req_valid = 1;
            prot_mode = ($urandom_range(0, 3) != 0);
            kind = 2'($urandom); size_m1 = 2'($urandom);
            seg_sel = 16'($urandom); desc_base = $urandom;
            desc_limit = ($urandom_range(0, 1) == 1) ? 20'hFFFFF : 20'($urandom);
            desc_gran = 1'($urandom); desc_code = 1'($urandom);
            desc_writable = 1'($urandom);
            desc_present = ($urandom_range(0, 7) != 0);
            desc_null = ($urandom_range(0, 7) == 0);
            desc_big = 1'($urandom);
            offset = ($urandom_range(0, 1) == 1) ? $urandom : 32'($urandom_range(0, 4200));
            step("R2 R10 random");
         end
      end

      // R12 reset clears outputs mid-traffic
      prot("R2 before reset", 1, 0, 32'h40, 20'hFFFFF, 1, 0, 1, 1, 0, 1, 32'h4);
      rst_n = 0;
      e_valid = 0; e_fault = 0; e_code = 0; e_addr = 0;
      @(negedge clk);
      compare("R12 reset again");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule